// File: doc/BRIEF.md
# Threshold-Paced DMA Data FIFO

This block is a byte-wide, sixteen-entry data FIFO that sits between a media-side data path and a host DMA channel. It drives a DMA request line whose assertion and release depend on the transfer direction and on a programmed threshold. In read mode the media side fills the FIFO and the DMA channel drains it. In write mode the DMA channel fills the FIFO and the media side drains it.

A transfer starts with a start pulse, which latches the direction, the enable bit and the threshold. It ends with a terminal-count pulse. While the FIFO is disabled, the block holds at most one byte, so each byte moves as a single DMA cycle. The media side paces itself from the occupancy output. The DMA side sees only the request line and an error flag.

Top module: `dma_thresh_fifo`

## Requirements
- R1: After reset the request and error outputs are 0, the occupancy is 0, and the block is idle.
- R2: With the FIFO enabled, capacity is 16 bytes and the effective threshold is the programmed 4-bit value plus one (1 to 16). Occupancy never exceeds capacity.
- R3: With the FIFO disabled, capacity is one byte and the effective threshold is 1. A second DMA write while one byte is held in write mode is refused.
- R4: In read mode (direction input 0), the request rises on the clock edge after occupancy reaches 16 minus the effective threshold. If that difference is 0, the request rises at one byte.
- R5: In read mode, a media byte pushed with the last-of-sector flag raises the request on the following edge, whatever the occupancy.
- R6: In read mode, once raised, the request stays high until the edge after occupancy reaches 0, and it falls on that edge.
- R7: In write mode (direction input 1), the request rises on the same edge that begins the transfer.
- R8: In write mode, the request falls on the edge after the FIFO becomes full. It rises again on the edge after occupancy has fallen to the effective threshold or below.
- R9: A terminal-count pulse ends the transfer. On that edge the request falls, the FIFO empties and the block goes idle.
- R10: A DMA strobe to a full FIFO in write mode, or to an empty FIFO in read mode, is ignored. It sets an error flag that stays set until the next transfer starts.
- R11: Bytes leave the FIFO in the order they entered, in both directions.
- R12: Direction, enable and threshold inputs are sampled only while idle. Changes during a transfer have no effect until it ends, and a start pulse during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | FIFO enable (1 = 16 bytes, 0 = single byte) |
| thresh_i | input | 4 | Programmed threshold, effective value is this plus one |
| dir_wr_i | input | 1 | Direction: 1 = DMA fills, 0 = DMA drains |
| start_i | input | 1 | Begin transfer pulse |
| tc_i | input | 1 | Terminal count pulse |
| med_push_i | input | 1 | Media byte into FIFO (read mode) |
| med_last_i | input | 1 | Marks the pushed media byte as last of sector |
| med_wdata_i | input | 8 | Media write data |
| med_pop_i | input | 1 | Media takes a byte (write mode) |
| med_rdata_o | output | 8 | Head byte for the media side |
| dma_stb_i | input | 1 | DMA access strobe, direction from mode |
| dma_wdata_i | input | 8 | DMA write data |
| dma_rdata_o | output | 8 | Head byte for the DMA side |
| dma_req_o | output | 1 | DMA request |
| dma_err_o | output | 1 | Sticky illegal-access flag |
| level_o | output | 5 | Current occupancy |

## Verification
The hardest case to reach is the one-cycle lag between occupancy and request. It matters most where a drain and a fill land in the same cycle near a boundary, for example a DMA strobe on the cycle the FIFO empties, while the request is still high from the previous edge. A random stream rarely lines these up on its own. The bench therefore runs long constrained-random transfers in which DMA strobes are more likely while the request is high, but still arrive while it is low. Terminal counts and configuration changes fall at random points inside transfers. Directed sequences walk each threshold edge, the last-of-sector path and the single-byte mode.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;
endpackage

// File: rtl/dfr_fifo_store.sv
module dfr_fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign level_o = lvl_q;

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> level_o < LW'(DEPTH));
  assert_no_underflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> level_o != '0);
endmodule

// File: rtl/dfr_req_gen.sv
module dfr_req_gen #(
  parameter int LW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          start_wr_i,
  input  logic          tc_i,
  input  logic          active_i,
  input  logic          wr_i,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] cap_i,
  input  logic [LW-1:0] thr_i,
  input  logic          push_last_i,
  output logic          req_o
);
  logic          req_q, last_q;
  logic [LW-1:0] rd_mark;
  logic          rd_next, wr_next;

  // read-side trigger level, never below one byte
  assign rd_mark = (cap_i > thr_i) ? cap_i - thr_i : LW'(1);
  assign rd_next = (level_i != '0) && (req_q || level_i >= rd_mark || last_q);
  assign wr_next = (level_i < cap_i) && (req_q || level_i <= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
    end else if (tc_i || start_i) begin
      last_q <= 1'b0;
    end else if (push_last_i) begin
      last_q <= 1'b1;
    end else if (level_i == '0) begin
      last_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       req_q <= 1'b0;
    else if (tc_i)     req_q <= 1'b0;
    else if (start_i)  req_q <= start_wr_i;
    else if (active_i) req_q <= wr_i ? wr_next : rd_next;
    else               req_q <= 1'b0;
  end

  assign req_o = req_q;

  assert_tc_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i |=> !req_o);
  assert_wr_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && start_wr_i && !tc_i |=> req_o);
  assert_rd_empty_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !wr_i && level_i == '0 && !start_i && !tc_i |=> !req_o);
  assert_wr_full_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && wr_i && level_i == cap_i && !start_i && !tc_i |=> !req_o);
  assert_req_in_xfer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> active_i);
endmodule

// File: rtl/dma_thresh_fifo.sv
module dma_thresh_fifo
  import dfr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int TW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic [TW-1:0] thresh_i,
  input  logic          dir_wr_i,
  input  logic          start_i,
  input  logic          tc_i,
  input  logic          med_push_i,
  input  logic          med_last_i,
  input  logic [DW-1:0] med_wdata_i,
  input  logic          med_pop_i,
  output logic [DW-1:0] med_rdata_o,
  input  logic          dma_stb_i,
  input  logic [DW-1:0] dma_wdata_i,
  output logic [DW-1:0] dma_rdata_o,
  output logic          dma_req_o,
  output logic          dma_err_o,
  output logic [LW-1:0] level_o
);
  logic          active_q, err_q, en_q;
  logic [TW-1:0] thr_q;
  dir_e          dir_q;
  logic          start_eff, xfer_ok, full, empty;
  logic          push_src, pop_src, push_ok, pop_ok, bad_dma;
  logic [LW-1:0] cap, thr_eff, level;
  logic [DW-1:0] wdata, rdata;

  assign start_eff = start_i && !active_q && !tc_i;
  assign xfer_ok   = active_q && !tc_i;

  // configuration follows the inputs only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      thr_q <= '0;
      dir_q <= DIR_RD;
    end else if (!active_q) begin
      en_q  <= fifo_en_i;
      thr_q <= thresh_i;
      dir_q <= dir_e'(dir_wr_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        active_q <= 1'b0;
    else if (tc_i)      active_q <= 1'b0;
    else if (start_eff) active_q <= 1'b1;
  end

  assign cap     = en_q ? LW'(DEPTH) : LW'(1);
  assign thr_eff = en_q ? LW'(thr_q) + LW'(1) : LW'(1);
  assign full    = level >= cap;
  assign empty   = level == '0;

  assign push_src = (dir_q == DIR_WR) ? dma_stb_i : med_push_i;
  assign pop_src  = (dir_q == DIR_WR) ? med_pop_i : dma_stb_i;
  assign wdata    = (dir_q == DIR_WR) ? dma_wdata_i : med_wdata_i;
  assign push_ok  = xfer_ok && push_src && !full;
  assign pop_ok   = xfer_ok && pop_src && !empty;
  assign bad_dma  = xfer_ok && dma_stb_i && ((dir_q == DIR_WR) ? full : empty);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (start_eff) err_q <= 1'b0;
    else if (bad_dma)   err_q <= 1'b1;
  end

  dfr_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (start_eff || tc_i),
    .push_i  (push_ok),
    .pop_i   (pop_ok),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .level_o (level)
  );

  dfr_req_gen #(.LW(LW)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_eff),
    .start_wr_i  (dir_wr_i),
    .tc_i        (tc_i),
    .active_i    (active_q),
    .wr_i        (dir_q == DIR_WR),
    .level_i     (level),
    .cap_i       (cap),
    .thr_i       (thr_eff),
    .push_last_i (push_ok && dir_q == DIR_RD && med_last_i),
    .req_o       (dma_req_o)
  );

  assign med_rdata_o = rdata;
  assign dma_rdata_o = rdata;
  assign dma_err_o   = err_q;
  assign level_o     = level;

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_err_o && !start_eff |=> dma_err_o);
  assert_cfg_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> $stable(thr_q) && $stable(en_q) && $stable(dir_q));
  assert_cap_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> level_o <= cap);
endmodule

// File: tb/dma_thresh_fifo_tb_top.sv
`timescale 1ns/1ps
module dma_thresh_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, dir = 1'b0, st = 1'b0, tc = 1'b0;
  logic [3:0] thr_in = '0;
  logic       mpush = 1'b0, mlast = 1'b0, mpop = 1'b0, stb = 1'b0;
  logic [7:0] mw = '0, dw = '0;
  logic [7:0] med_rd, dma_rd;
  logic       req, err;
  logic [4:0] lvl;

  int checks = 0;
  int fails  = 0;

  // reference state
  bit       m_active, m_wr, m_en, m_req, m_err, m_last;
  int       m_thr, m_level, m_rp, m_wp;
  logic [7:0] m_mem [16];

  always #4 clk = ~clk;

  dma_thresh_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(en), .thresh_i(thr_in),
    .dir_wr_i(dir), .start_i(st), .tc_i(tc), .med_push_i(mpush),
    .med_last_i(mlast), .med_wdata_i(mw), .med_pop_i(mpop),
    .med_rdata_o(med_rd), .dma_stb_i(stb), .dma_wdata_i(dw),
    .dma_rdata_o(dma_rd), .dma_req_o(req), .dma_err_o(err), .level_o(lvl)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rd_mark(int cap, int thr);
    return (cap > thr) ? cap - thr : 1;
  endfunction

  task automatic quiet();
    st = 0; tc = 0; mpush = 0; mlast = 0; mpop = 0; stb = 0;
  endtask

  task automatic step();
    int cap, thr;
    bit se, xok, full, emp, pu, po, bad;
    bit n_req, n_last, n_err, n_act;
    cap  = m_en ? 16 : 1;
    thr  = m_en ? m_thr + 1 : 1;
    se   = st && !m_active && !tc;
    xok  = m_active && !tc;
    full = m_level >= cap;
    emp  = m_level == 0;
    pu   = xok && (m_wr ? stb : mpush) && !full;
    po   = xok && (m_wr ? mpop : stb) && !emp;
    bad  = xok && stb && (m_wr ? full : emp);
    if (tc) n_req = 0;
    else if (se) n_req = dir;
    else if (m_active)
      n_req = m_wr ? (m_level < cap && (m_req || m_level <= thr))
                   : (m_level != 0 && (m_req || m_level >= rd_mark(cap, thr) || m_last));
    else n_req = 0;
    if (tc || se) n_last = 0;
    else if (pu && !m_wr && mlast) n_last = 1;
    else if (m_level == 0) n_last = 0;
    else n_last = m_last;
    n_err = se ? 0 : (bad ? 1 : m_err);
    n_act = tc ? 0 : (se ? 1 : m_active);
    if (pu) m_mem[m_wp] = m_wr ? dw : mw;
    if (tc || se) begin
      m_level = 0; m_rp = 0; m_wp = 0;
    end else begin
      if (pu) m_wp = (m_wp + 1) % 16;
      if (po) m_rp = (m_rp + 1) % 16;
      m_level = m_level + int'(pu) - int'(po);
    end
    if (!m_active) begin
      m_en = en; m_thr = thr_in; m_wr = dir;
    end
    m_req = n_req; m_last = n_last; m_err = n_err; m_active = n_act;
    @(posedge clk);
    @(negedge clk);
    chk(m_wr ? "R8 write request" : "R4 read request", req, m_req);
    chk("R2 occupancy", lvl, m_level);
    chk("R10 error flag", err, m_err);
    if (m_active && m_level > 0) begin
      if (m_wr) chk("R11 media data order", med_rd, m_mem[m_rp]);
      else      chk("R11 dma data order", dma_rd, m_mem[m_rp]);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic begin_xfer(bit e, int t, bit d);
    quiet(); en = e; thr_in = 4'(t); dir = d; st = 1; step(); quiet();
  endtask

  task automatic end_xfer();
    quiet(); tc = 1; step(); quiet();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_active = 0; m_wr = 0; m_en = 0; m_req = 0; m_err = 0; m_last = 0;
    m_thr = 0; m_level = 0; m_rp = 0; m_wp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset request", req, 0);
    chk("R1 reset error", err, 0);
    chk("R1 reset level", lvl, 0);

    // R4, R6: read, threshold 4 -> trigger at 12 bytes
    begin_xfer(1, 3, 0);
    mpush = 1;
    for (int i = 0; i < 11; i++) begin mw = 8'(i + 1); step(); end
    mw = 8'd12; step();
    chk("R4 no request same edge as 12th byte", req, 0);
    quiet(); step();
    chk("R4 request after 12 bytes", req, 1);
    stb = 1; run(12);
    chk("R6 request held at empty edge", req, 1);
    chk("R6 level empty", lvl, 0);
    quiet(); step();
    chk("R6 request released after empty", req, 0);

    // R5: last-of-sector early request
    mpush = 1; mw = 8'hA1; step();
    mlast = 1; mw = 8'hA2; step();
    quiet();
    chk("R5 not yet raised", req, 0);
    step();
    chk("R5 raised by last byte", req, 1);
    end_xfer();
    chk("R9 request dropped on tc", req, 0);
    chk("R9 fifo flushed on tc", lvl, 0);

    // R7, R8, R10: write, threshold 4
    begin_xfer(1, 3, 1);
    chk("R7 request at start", req, 1);
    stb = 1;
    for (int i = 0; i < 16; i++) begin dw = 8'(8'h40 + i); step(); end
    quiet(); step();
    chk("R8 release when full", req, 0);
    stb = 1; dw = 8'hFF; step(); quiet();
    chk("R10 error on full write", err, 1);
    chk("R10 full write ignored", lvl, 16);
    mpop = 1; run(12); quiet();
    chk("R8 not yet reasserted", req, 0);
    step();
    chk("R8 reassert at threshold", req, 1);
    end_xfer();
    chk("R9 write request dropped", req, 0);

    // R3: disabled FIFO, single byte
    begin_xfer(0, 9, 1);
    chk("R10 error cleared at start", err, 0);
    stb = 1; dw = 8'h5C; step(); quiet();
    chk("R3 one byte held", lvl, 1);
    step();
    chk("R3 request off with one byte", req, 0);
    stb = 1; dw = 8'h11; step(); quiet();
    chk("R3 second byte refused", lvl, 1);
    chk("R3 refused write flags error", err, 1);
    end_xfer();

    // R12: config changes during transfer ignored
    begin_xfer(1, 15, 0);
    en = 0; thr_in = 4'd0; dir = 1;
    mpush = 1; mw = 8'h01; step(); mw = 8'h02; step(); mw = 8'h03; step(); quiet();
    chk("R12 capacity kept at 16", lvl, 3);
    chk("R12 read mode kept", req, 1);
    st = 1; dir = 1; step(); quiet();
    chk("R12 start ignored while active", lvl, 3);
    end_xfer();

    // constrained random
    for (int i = 0; i < 30000; i++) begin
      quiet();
      if (!m_active) begin
        en = ($urandom_range(0, 3) != 0);
        thr_in = 4'($urandom_range(0, 15));
        dir = 1'($urandom_range(0, 1));
        st = ($urandom_range(0, 3) == 0);
      end else begin
        if ($urandom_range(0, 19) == 0) begin
          en = 1'($urandom_range(0, 1));
          thr_in = 4'($urandom_range(0, 15));
          dir = 1'($urandom_range(0, 1));
        end
        st    = ($urandom_range(0, 63) == 0);
        tc    = ($urandom_range(0, 199) == 0);
        mpush = ($urandom_range(0, 2) == 0);
        mlast = ($urandom_range(0, 15) == 0);
        mpop  = ($urandom_range(0, 2) == 0);
        stb   = req ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 9) == 0);
        mw    = 8'($urandom);
        dw    = 8'($urandom);
      end
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule